// File: doc/BRIEF.md
# Link Power State Machine with Physical Request Resolver

This block keeps the power state of each link layer of a multi-protocol link. Every link layer has its own state machine instance that owns that layer's power state. An instance changes state for one of two reasons only: a request from its local link layer, or a management packet from the far side of the link. It answers the far side with request and status packets of its own. The instance reports its current state to its link layer. A resolver merges the states of all instances into one request toward the physical layer.

The machine works like a handshake engine, not a free-running power FSM. Entry into low power needs a request sent by this side and a matching status received from the far side. Packets that arrive in the wrong state, repeated requests, a local and a remote request in the same cycle, and packets with reserved content all have one fixed outcome. Decoded packets arrive as a valid strobe with a request/status flag, a 2-bit target-state field and a reserved field. The physical layer reports with a single recovery-complete strobe. Every output is registered and changes on the clock edge that samples its cause.

Top module: `lpsm_top`

## Requirements
- R1: While reset is high, and on the first edge after it, every instance reports state Reset, transmits nothing, and the physical request is idle (00). State codes on `link_state`: Reset=0, Active=1, LowPowerPending=2, LowPower=3, Retrain=4, Recovery=5.
- R2: A local go-active in Reset transmits one Active Request (`tx_is_sts`=0, `tx_tgt`=01) and marks an activation as pending. The instance stays in Reset until an Active Status (`rx_is_sts`=1, `rx_tgt`=01) or an Active Request arrives, and then moves to Active. An Active Request received in Reset or LowPowerPending is answered with an Active Status and leads to Active.
- R3: While an activation is pending, a received LowPower request or LowPower status (target 10) moves the instance to Recovery.
- R4: A local go-low-power in Active transmits a LowPower Request and moves the instance to LowPowerPending. LowPower is entered only from LowPowerPending on receipt of a LowPower Status.
- R5: An Active Request received in LowPower moves the instance to Retrain and is answered with an Active Status. A local go-active in LowPower transmits an Active Request, moves the instance to Retrain and marks an activation as pending.
- R6: A packet whose target is reserved (00 or 11), or whose reserved field is non-zero, moves any instance that is not in Recovery to Recovery.
- R7: A redundant request is answered with the matching status and leaves the state unchanged. This covers an Active Request in Active or Retrain, and a LowPower Request in Active, LowPowerPending or LowPower.
- R8: When a valid remote packet and a local request arrive in the same cycle, only the packet is acted on and the local request is dropped.
- R9: On recovery-complete, Recovery goes to Reset and clears any pending activation, and Retrain goes to Active if no activation is pending. Recovery ignores every packet and every local request.
- R10: The physical request is retrain (11) if any instance is in Retrain or Recovery. Otherwise it is low power (10) if every instance is in LowPower, otherwise active (01) if any instance is in Active or LowPowerPending, and otherwise idle (00).
- R11: A well-formed packet that has no meaning in the current state, such as a status with nothing pending or a LowPower Status outside LowPowerPending, changes neither the state nor the transmit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_go_active | input | N_LINKS | Per-link local request to become active |
| loc_go_lowpwr | input | N_LINKS | Per-link local request to enter low power |
| rx_valid | input | N_LINKS | Per-link decoded packet strobe |
| rx_is_sts | input | N_LINKS | Packet is a status (1) or a request (0) |
| rx_tgt | input | 2*N_LINKS | Packet target state, 01 Active, 10 LowPower |
| rx_rsvd | input | RSVD_W*N_LINKS | Packet reserved field, must be zero |
| phy_recov_done | input | 1 | Physical layer finished retraining |
| tx_valid | output | N_LINKS | Per-link packet to transmit |
| tx_is_sts | output | N_LINKS | Transmitted packet is a status |
| tx_tgt | output | 2*N_LINKS | Transmitted target state |
| link_state | output | 3*N_LINKS | Per-link state code |
| phy_req | output | 2 | Resolved request to the physical layer |

## Verification
Two kinds of event can land on one instance in the same cycle: a local request and a remote packet (R8), and the recovery-complete strobe together with a packet in Retrain. The bench provokes the first on purpose with a go-low-power from Active paired with an incoming Active Request. Both kinds also occur often under random stimulus. A bench model decides each case from the requirements: the packet wins, the local request leaves no trace on the transmit port, and Retrain exits only when the activation is no longer pending after the packet has been handled.

// File: rtl/lpsm_pkg.sv
package lpsm_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_ACTIVE  = 3'd1,
        ST_LP_PEND = 3'd2,
        ST_LOWPWR  = 3'd3,
        ST_RETRAIN = 3'd4,
        ST_RECOV   = 3'd5
    } pstate_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_ACT_REQ,
        K_ACT_STS,
        K_LP_REQ,
        K_LP_STS,
        K_BAD
    } pkind_e;

    typedef enum logic [1:0] {
        PR_IDLE    = 2'd0,
        PR_ACTIVE  = 2'd1,
        PR_LOWPWR  = 2'd2,
        PR_RETRAIN = 2'd3
    } phyreq_e;

    localparam logic [1:0] TGT_ACT = 2'b01;
    localparam logic [1:0] TGT_LP  = 2'b10;
    localparam int STATE_W = 3;

    typedef struct packed {
        logic       valid;
        logic       is_sts;
        logic [1:0] tgt;
    } msg_t;

    function automatic msg_t mk_msg(input logic sts, input logic [1:0] tgt);
        msg_t m;
        m.valid  = 1'b1;
        m.is_sts = sts;
        m.tgt    = tgt;
        return m;
    endfunction

    localparam msg_t MSG_NONE = '0;

endpackage

// File: rtl/lpsm_rx_decode.sv
module lpsm_rx_decode
    import lpsm_pkg::*;
#(
    parameter int RSVD_W = 4
) (
    input  logic              rx_valid,
    input  logic              rx_is_sts,
    input  logic [1:0]        rx_tgt,
    input  logic [RSVD_W-1:0] rx_rsvd,
    output pkind_e            kind
);
    always_comb begin
        if (!rx_valid) begin
            kind = K_NONE;
        end else if ((|rx_rsvd) || (rx_tgt != TGT_ACT && rx_tgt != TGT_LP)) begin
            kind = K_BAD;
        end else if (rx_tgt == TGT_ACT) begin
            kind = rx_is_sts ? K_ACT_STS : K_ACT_REQ;
        end else begin
            kind = rx_is_sts ? K_LP_STS : K_LP_REQ;
        end
    end
endmodule

// File: rtl/lpsm_vlsm.sv
module lpsm_vlsm
    import lpsm_pkg::*;
#(
    parameter int RSVD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_go_active,
    input  logic              loc_go_lowpwr,
    input  logic              rx_valid,
    input  logic              rx_is_sts,
    input  logic [1:0]        rx_tgt,
    input  logic [RSVD_W-1:0] rx_rsvd,
    input  logic              recov_done,
    output pstate_e           state,
    output msg_t              tx
);
    pkind_e  kind;
    pstate_e nst;
    logic    pend, npend;
    msg_t    ntx;

    lpsm_rx_decode #(.RSVD_W(RSVD_W)) u_dec (
        .rx_valid (rx_valid),
        .rx_is_sts(rx_is_sts),
        .rx_tgt   (rx_tgt),
        .rx_rsvd  (rx_rsvd),
        .kind     (kind)
    );

    always_comb begin
        nst   = state;
        npend = pend;
        ntx   = MSG_NONE;
        if (state == ST_RECOV) begin
            if (recov_done) begin
                nst   = ST_RESET;
                npend = 1'b0;
            end
        end else if (kind == K_BAD ||
                     (pend && (kind == K_LP_REQ || kind == K_LP_STS))) begin
            nst   = ST_RECOV;
            npend = 1'b0;
        end else if (kind != K_NONE) begin
            unique case (kind)
                K_ACT_REQ: begin
                    ntx   = mk_msg(1'b1, TGT_ACT);
                    npend = 1'b0;
                    if (state == ST_RESET || state == ST_LP_PEND) nst = ST_ACTIVE;
                    else if (state == ST_LOWPWR)                 nst = ST_RETRAIN;
                end
                K_ACT_STS: begin
                    if (pend) begin
                        npend = 1'b0;
                        if (state == ST_RESET) nst = ST_ACTIVE;
                    end
                end
                K_LP_REQ: begin
                    if (state == ST_ACTIVE || state == ST_LP_PEND || state == ST_LOWPWR)
                        ntx = mk_msg(1'b1, TGT_LP);
                end
                K_LP_STS: begin
                    if (state == ST_LP_PEND) nst = ST_LOWPWR;
                end
                default: ;
            endcase
        end else if (loc_go_active) begin
            if (state == ST_RESET && !pend) begin
                ntx   = mk_msg(1'b0, TGT_ACT);
                npend = 1'b1;
            end else if (state == ST_LOWPWR) begin
                ntx   = mk_msg(1'b0, TGT_ACT);
                npend = 1'b1;
                nst   = ST_RETRAIN;
            end
        end else if (loc_go_lowpwr) begin
            if (state == ST_ACTIVE) begin
                ntx = mk_msg(1'b0, TGT_LP);
                nst = ST_LP_PEND;
            end
        end
        if (state == ST_RETRAIN && nst == ST_RETRAIN && recov_done && !npend)
            nst = ST_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET;
            pend  <= 1'b0;
            tx    <= MSG_NONE;
        end else begin
            state <= nst;
            pend  <= npend;
            tx    <= ntx;
        end
    end

    // R1: reset leaves the instance quiet in Reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (state == ST_RESET && !tx.valid));

    // R3: unexpected LowPower packet while activation pending
    assert_pend_unexpected_R3: assert property (@(posedge clk) disable iff (rst)
        (pend && state != ST_RECOV && (kind == K_LP_REQ || kind == K_LP_STS))
        |=> state == ST_RECOV);

    // R4: LowPower only from LowPowerPending with a LowPower status
    assert_lowpwr_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOWPWR && $past(state) != ST_LOWPWR)
        |-> ($past(state) == ST_LP_PEND && $past(kind) == K_LP_STS));

    // R5: Active Request in LowPower goes to Retrain with a status reply
    assert_lowpwr_wake_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOWPWR && kind == K_ACT_REQ)
        |=> (state == ST_RETRAIN && tx.valid && tx.is_sts && tx.tgt == TGT_ACT));

    // R6: malformed packet sends the instance to Recovery
    assert_bad_pkt_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RECOV && kind == K_BAD) |=> state == ST_RECOV);

    // R9: Recovery is left only through Reset after recovery-complete
    assert_recov_exit_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RECOV && state != ST_RECOV)
        |-> (state == ST_RESET && $past(recov_done)));

endmodule

// File: rtl/lpsm_resolve.sv
module lpsm_resolve
    import lpsm_pkg::*;
#(
    parameter int N_LINKS = 2,
    localparam int SW = STATE_W
) (
    input  logic [SW*N_LINKS-1:0] st_flat,
    output logic [1:0]            phy_req
);
    logic [N_LINKS-1:0] is_rt, is_lp, is_act;

    for (genvar i = 0; i < N_LINKS; i++) begin : g_flag
        pstate_e s;
        assign s         = pstate_e'(st_flat[i*SW +: SW]);
        assign is_rt[i]  = (s == ST_RETRAIN) || (s == ST_RECOV);
        assign is_lp[i]  = (s == ST_LOWPWR);
        assign is_act[i] = (s == ST_ACTIVE) || (s == ST_LP_PEND);
    end

    always_comb begin
        if (|is_rt)       phy_req = PR_RETRAIN;
        else if (&is_lp)  phy_req = PR_LOWPWR;
        else if (|is_act) phy_req = PR_ACTIVE;
        else              phy_req = PR_IDLE;
    end
endmodule

// File: rtl/lpsm_top.sv
module lpsm_top
    import lpsm_pkg::*;
#(
    parameter int N_LINKS = 2,
    parameter int RSVD_W  = 4,
    localparam int SW = STATE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_LINKS-1:0]        loc_go_active,
    input  logic [N_LINKS-1:0]        loc_go_lowpwr,
    input  logic [N_LINKS-1:0]        rx_valid,
    input  logic [N_LINKS-1:0]        rx_is_sts,
    input  logic [2*N_LINKS-1:0]      rx_tgt,
    input  logic [RSVD_W*N_LINKS-1:0] rx_rsvd,
    input  logic                     phy_recov_done,
    output logic [N_LINKS-1:0]        tx_valid,
    output logic [N_LINKS-1:0]        tx_is_sts,
    output logic [2*N_LINKS-1:0]      tx_tgt,
    output logic [SW*N_LINKS-1:0]     link_state,
    output logic [1:0]               phy_req
);
    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
        pstate_e st;
        msg_t    m;
        lpsm_vlsm #(.RSVD_W(RSVD_W)) u_vlsm (
            .clk          (clk),
            .rst          (rst),
            .loc_go_active(loc_go_active[i]),
            .loc_go_lowpwr(loc_go_lowpwr[i]),
            .rx_valid     (rx_valid[i]),
            .rx_is_sts    (rx_is_sts[i]),
            .rx_tgt       (rx_tgt[2*i +: 2]),
            .rx_rsvd      (rx_rsvd[RSVD_W*i +: RSVD_W]),
            .recov_done   (phy_recov_done),
            .state        (st),
            .tx           (m)
        );
        assign link_state[SW*i +: SW] = st;
        assign tx_valid[i]            = m.valid;
        assign tx_is_sts[i]           = m.is_sts;
        assign tx_tgt[2*i +: 2]       = m.tgt;
    end

    lpsm_resolve #(.N_LINKS(N_LINKS)) u_res (
        .st_flat(link_state),
        .phy_req(phy_req)
    );

    logic [N_LINKS-1:0] all_lp_v, any_rt_v;
    for (genvar i = 0; i < N_LINKS; i++) begin : g_chk
        assign all_lp_v[i] = (link_state[SW*i +: SW] == ST_LOWPWR);
        assign any_rt_v[i] = (link_state[SW*i +: SW] == ST_RETRAIN) ||
                             (link_state[SW*i +: SW] == ST_RECOV);
    end

    // R10: retrain wins over every other request
    assert_phy_retrain_R10: assert property (@(posedge clk) disable iff (rst)
        (|any_rt_v) |-> phy_req == PR_RETRAIN);

    // R10: low power is asked only when all instances sit in LowPower
    assert_phy_lowpwr_R10: assert property (@(posedge clk) disable iff (rst)
        (phy_req == PR_LOWPWR) |-> (&all_lp_v));

endmodule

// File: tb/lpsm_top_test.sv
module lpsm_top_test;
    localparam int N = 2;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]    ga, glp, rv, rs;
    logic [2*N-1:0]  tg;
    logic [RW*N-1:0] rsv;
    logic            rd;
    logic [N-1:0]    tx_valid, tx_is_sts;
    logic [2*N-1:0]  tx_tgt;
    logic [3*N-1:0]  link_state;
    logic [1:0]      phy_req;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int    m_st[N];
    bit    m_pend[N];

    always #2.5 clk = ~clk;

    lpsm_top #(.N_LINKS(N), .RSVD_W(RW)) uut (
        .clk(clk), .rst(rst),
        .loc_go_active(ga), .loc_go_lowpwr(glp),
        .rx_valid(rv), .rx_is_sts(rs), .rx_tgt(tg), .rx_rsvd(rsv),
        .phy_recov_done(rd),
        .tx_valid(tx_valid), .tx_is_sts(tx_is_sts), .tx_tgt(tx_tgt),
        .link_state(link_state), .phy_req(phy_req)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model(input int st, input bit pend, input bit lga, input bit llp,
                         input bit v, input bit sts, input logic [1:0] t,
                         input logic [RW-1:0] r, input bit done,
                         output int nst, output bit npend, output bit tv, output bit ts,
                         output logic [1:0] tt, output string tag);
        int k; // 0 none 1 actreq 2 actsts 3 lpreq 4 lpsts 5 bad
        nst = st; npend = pend; tv = 0; ts = 0; tt = 2'b00; tag = "R11";
        if (!v) k = 0;
        else if (r != 0 || t == 2'b00 || t == 2'b11) k = 5;
        else if (t == 2'b01) k = sts ? 2 : 1;
        else k = sts ? 4 : 3;
        if (st == 5) begin
            tag = "R9";
            if (done) begin nst = 0; npend = 0; end
        end else if (k == 5) begin
            nst = 5; npend = 0; tag = "R6";
        end else if (pend && (k == 3 || k == 4)) begin
            nst = 5; npend = 0; tag = "R3";
        end else if (k != 0) begin
            if (k == 1) begin
                tv = 1; ts = 1; tt = 2'b01; npend = 0;
                if (st == 0 || st == 2) begin nst = 1; tag = "R2"; end
                else if (st == 3) begin nst = 4; tag = "R5"; end
                else tag = "R7";
            end else if (k == 2) begin
                if (pend) begin npend = 0; tag = "R2"; if (st == 0) nst = 1; end
            end else if (k == 3) begin
                if (st == 1 || st == 2 || st == 3) begin tv = 1; ts = 1; tt = 2'b10; tag = "R7"; end
            end else begin
                if (st == 2) begin nst = 3; tag = "R4"; end
            end
            if (lga || llp) tag = "R8";
        end else if (lga) begin
            if (st == 0 && !pend) begin tv = 1; tt = 2'b01; npend = 1; tag = "R2"; end
            else if (st == 3) begin tv = 1; tt = 2'b01; npend = 1; nst = 4; tag = "R5"; end
        end else if (llp) begin
            if (st == 1) begin tv = 1; tt = 2'b10; nst = 2; tag = "R4"; end
        end
        if (st == 4 && nst == 4 && done && !npend) begin nst = 1; tag = "R9"; end
    endtask

    function automatic int resolve_exp();
        bit any_rt = 0, all_lp = 1, any_act = 0;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 4 || m_st[i] == 5) any_rt = 1;
            if (m_st[i] != 3) all_lp = 0;
            if (m_st[i] == 1 || m_st[i] == 2) any_act = 1;
        end
        if (any_rt) return 3;
        if (all_lp) return 2;
        if (any_act) return 1;
        return 0;
    endfunction

    task automatic clear_in();
        ga = '0; glp = '0; rv = '0; rs = '0; tg = '0; rsv = '0; rd = 1'b0;
    endtask

    task automatic pkt(input int l, input bit sts, input logic [1:0] t, input logic [RW-1:0] r);
        rv[l] = 1'b1; rs[l] = sts; tg[2*l +: 2] = t; rsv[RW*l +: RW] = r;
    endtask

    // inputs are already set (driven after a negedge); evaluate one edge
    task automatic step();
        int    nst[N];
        bit    np[N], tv[N], ts[N];
        logic [1:0] tt[N];
        string tag[N];
        for (int l = 0; l < N; l++)
            model(m_st[l], m_pend[l], ga[l], glp[l], rv[l], rs[l], tg[2*l +: 2],
                  rsv[RW*l +: RW], rd, nst[l], np[l], tv[l], ts[l], tt[l], tag[l]);
        @(posedge clk);
        #1;
        for (int l = 0; l < N; l++) begin
            m_st[l] = nst[l]; m_pend[l] = np[l];
            check(tag[l], $sformatf("link%0d state", l), int'(link_state[3*l +: 3]), nst[l]);
            check(tag[l], $sformatf("link%0d tx_valid", l), int'(tx_valid[l]), int'(tv[l]));
            if (tv[l]) begin
                check(tag[l], $sformatf("link%0d tx_is_sts", l), int'(tx_is_sts[l]), int'(ts[l]));
                check(tag[l], $sformatf("link%0d tx_tgt", l), int'(tx_tgt[2*l +: 2]), int'(tt[l]));
            end
        end
        check("R10", "phy_req", int'(phy_req), resolve_exp());
        @(negedge clk);
        clear_in();
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        clear_in();
        for (int l = 0; l < N; l++) begin m_st[l] = 0; m_pend[l] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        for (int l = 0; l < N; l++) begin
            check("R1", "reset state", int'(link_state[3*l +: 3]), 0);
            check("R1", "reset tx_valid", int'(tx_valid[l]), 0);
        end
        check("R1", "reset phy_req", int'(phy_req), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: local activation handshake on link 0, remote-initiated on link 1
        ga[0] = 1; step();
        ga[0] = 1; step();                       // repeat ignored while pending
        pkt(0, 1, 2'b01, '0); pkt(1, 0, 2'b01, '0); step();
        // R7: redundant LowPower request answered, state kept
        pkt(0, 0, 2'b10, '0); step();
        pkt(0, 0, 2'b10, '0); step();
        // R7: redundant Active Request in Active
        pkt(1, 0, 2'b01, '0); step();
        // R11: stray status ignored
        pkt(1, 1, 2'b01, '0); step();
        pkt(1, 1, 2'b10, '0); step();
        // R4: both links enter LowPower -> R10 low power request
        glp[0] = 1; glp[1] = 1; step();
        pkt(0, 1, 2'b10, '0); step();
        pkt(1, 1, 2'b10, '0); step();
        // R5: remote wake of link 0 -> Retrain, R9 exit on recovery-complete
        pkt(0, 0, 2'b01, '0); step();
        rd = 1; step();
        // R5 local wake of link 1, then R3 unexpected packet while pending
        ga[1] = 1; step();
        pkt(1, 1, 2'b10, '0); step();
        rd = 1; step();
        // R8: local go-low-power and remote Active Request in one cycle
        glp[0] = 1; pkt(0, 0, 2'b01, '0); step();
        // R6: non-zero reserved field and reserved target
        pkt(0, 0, 2'b01, 4'h4); pkt(1, 1, 2'b11, '0); step();
        // R9: Recovery ignores packets and local requests until done
        pkt(0, 0, 2'b01, '0); ga[1] = 1; step();
        rd = 1; step();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            for (int l = 0; l < N; l++) begin
                int r;
                ga[l]  = ($urandom % 8) == 0;
                glp[l] = ($urandom % 6) == 0;
                rv[l]  = ($urandom % 3) == 0;
                rs[l]  = $urandom % 2;
                r = $urandom % 16;
                tg[2*l +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : (r[0] ? 2'b01 : 2'b10);
                rsv[RW*l +: RW] = (($urandom % 24) == 0) ? RW'(($urandom % 15) + 1) : '0;
            end
            rd = ($urandom % 5) == 0;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule